// File: doc/BRIEF.md
# Pseudo-SRAM Low-Power Key Register

This block holds the low-power configuration of a pseudo-static RAM. A dedicated program strobe captures a key from a handful of address lines: two lines choose the low-power mode, three others choose which address region keeps its data. All other address lines are ignored while the key is captured. The key may be written only once after power-up (modelled by reset), and only if no ordinary memory access has happened since. A rejected or malformed attempt raises a sticky error flag and leaves the stored key as it was.

When the host requests power-down (the second chip select driven low), the block switches to the stored mode and narrows its region-validity mask to the region the mode preserves. When the request is withdrawn the block returns to active mode. The mask keeps showing which regions still hold valid data. With no key ever written, power-down uses the sleep mode, which keeps nothing. The memory array and all analog behaviour lie outside this block.

Top module: `psram_pd_keyreg`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `mode_o`=0 (active), `mask_o` all ones and `err_o`=0, and the stored key becomes the default.
- R2: `mode_o` encodes 0=active, 1=nap, 2=partial retention, 3=sleep. The mode key is taken from (addr[0], addr[8]): (0,0) gives nap, (1,0) gives partial, (1,1) gives sleep, and (0,1) is reserved.
- R3: The area key is {addr[18], addr[21], addr[20]}. 000 selects the bottom region (`mask_o` bit 0, starting at the lowest address). 111 selects the top region (bit NSEG-1, ending at the highest address). Every other value is reserved.
- R4: For nap and sleep the area key is ignored: a reserved area value raises no error and the key is accepted.
- R5: With no accepted key since reset, a power-down uses the sleep mode.
- R6: A program strobe after a key has already been accepted sets `err_o` and leaves the stored key unchanged.
- R7: A program strobe after any earlier `acc_stb` since reset sets `err_o` and leaves the key unchanged. An access in the same cycle as the program strobe does not count as earlier.
- R8: A reserved mode key, or a reserved area key together with partial mode, sets `err_o`, stores nothing, and does not use up the one-time write.
- R9: Address bits other than 0, 8, 18, 20 and 21 have no effect on the captured key.
- R10: `pd_req` high at an edge moves `mode_o` from active to the stored mode after that edge, and holds it while `pd_req` stays high. `pd_req` low at an edge gives `mode_o`=0 after it.
- R11: On entry to power-down, `mask_o` is ANDed with the retained-region mask: one bit for partial mode, none for nap or sleep. It never regains bits until reset.
- R12: While `pd_req` is high, `pgm_stb` and `acc_stb` are ignored: no error, no key change, and the access is not recorded.
- R13: Once set, `err_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, stands for power-up |
| addr | input | ADDR_W (22) | Address bus; key lines are sampled on a program strobe |
| pgm_stb | input | 1 | Program strobe: capture a key from `addr` this cycle |
| acc_stb | input | 1 | Ordinary read or write took place this cycle |
| pd_req | input | 1 | Power-down request (second chip select low) |
| mode_o | output | 2 | Current mode: 0 active, 1 nap, 2 partial, 3 sleep |
| mask_o | output | NSEG (4) | Regions whose contents are still valid; bit 0 is the bottom region |
| err_o | output | 1 | Sticky error: rejected or reserved program attempt |

## Verification
The checker watches four things on every cycle: the error flag never falls, the mode tracks the power-down request one cycle later and holds while the request stays high, the validity mask only ever loses bits, and nap or sleep always shows an empty mask while partial shows at most one region. Other rules can only be shown by the bench's scenarios, because they depend on the history of strobes and keys. These are the one-time write, rejection after an access, rejection of reserved codes, the default sleep key, the don't-care address lines, and strobes ignored during power-down. Each scenario reads the stored key back through the mode and mask of a later power-down.

// File: rtl/pd_key_pkg.sv
package pd_key_pkg;

    // Output mode encoding; the key decoder never produces PWR_ACTIVE.
    typedef enum logic [1:0] {
        PWR_ACTIVE  = 2'd0,
        PWR_NAP     = 2'd1,
        PWR_PARTIAL = 2'd2,
        PWR_SLEEP   = 2'd3
    } pwr_mode_e;

    typedef enum logic [0:0] {
        AREA_LOW  = 1'b0,
        AREA_HIGH = 1'b1
    } area_e;

    typedef struct packed {
        pwr_mode_e mode;
        area_e     area;
    } pd_key_t;

    typedef struct packed {
        logic    ok;
        pd_key_t key;
    } key_dec_t;

    // Address line positions that carry the key.
    localparam int MODE_BIT_A = 0;
    localparam int MODE_BIT_B = 8;
    localparam int AREA_BIT_A = 18;
    localparam int AREA_BIT_B = 21;
    localparam int AREA_BIT_C = 20;
    localparam int KEY_TOP_BIT = 21;

    localparam pd_key_t KEY_DEFAULT = '{mode: PWR_SLEEP, area: AREA_LOW};

    function automatic key_dec_t decode_key(input logic ma, input logic mb,
                                            input logic [2:0] ar);
        key_dec_t d;
        logic     area_ok;
        d.key     = KEY_DEFAULT;
        d.ok      = 1'b1;
        area_ok   = (ar == 3'b000) || (ar == 3'b111);
        d.key.area = (ar == 3'b111) ? AREA_HIGH : AREA_LOW;
        unique case ({ma, mb})
            2'b00:   d.key.mode = PWR_NAP;
            2'b10: begin
                d.key.mode = PWR_PARTIAL;
                d.ok       = area_ok;
            end
            2'b11:   d.key.mode = PWR_SLEEP;
            default: d.ok = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pd_key_decode.sv
module pd_key_decode
    import pd_key_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [ADDR_W-1:0] addr,
    output key_dec_t          dec
);
    logic [2:0] area_code;
    logic       dc_unused;

    assign area_code = {addr[AREA_BIT_A], addr[AREA_BIT_B], addr[AREA_BIT_C]};
    assign dec       = decode_key(addr[MODE_BIT_A], addr[MODE_BIT_B], area_code);
    // Remaining address lines are don't-care for the key.
    assign dc_unused = ^addr;
endmodule

// File: rtl/pd_key_store.sv
module pd_key_store
    import pd_key_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     live,
    input  logic     pgm_stb,
    input  logic     acc_stb,
    input  key_dec_t dec,
    output pd_key_t  key_q,
    output logic     err_q
);
    logic locked_q;
    logic touched_q;
    logic pgm_live;
    logic reject;

    assign pgm_live = pgm_stb && live;
    assign reject   = locked_q || touched_q || !dec.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q     <= KEY_DEFAULT;
            locked_q  <= 1'b0;
            touched_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (pgm_live) begin
                if (reject) begin
                    err_q <= 1'b1;
                end else begin
                    key_q    <= dec.key;
                    locked_q <= 1'b1;
                end
            end
            if (acc_stb && live) begin
                touched_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pd_power_ctrl.sv
module pd_power_ctrl
    import pd_key_pkg::*;
#(
    parameter int NSEG = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pd_req,
    input  pd_key_t         key,
    output pwr_mode_e       mode_q,
    output logic [NSEG-1:0] mask_q
);
    localparam int TOP_SEG = NSEG - 1;

    logic [NSEG-1:0] keep;

    // Retained-region mask for the stored key; one bit per region.
    for (genvar g = 0; g < NSEG; g++) begin : g_keep
        localparam bit IS_BOT = (g == 0);
        localparam bit IS_TOP = (g == TOP_SEG);
        assign keep[g] = (key.mode == PWR_PARTIAL) &&
                         ((IS_BOT && key.area == AREA_LOW) ||
                          (IS_TOP && key.area == AREA_HIGH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PWR_ACTIVE;
            mask_q <= '1;
        end else if (pd_req) begin
            if (mode_q == PWR_ACTIVE) begin
                mode_q <= key.mode;
                mask_q <= mask_q & keep;
            end
        end else begin
            mode_q <= PWR_ACTIVE;
        end
    end
endmodule

// File: rtl/psram_pd_keyreg.sv
module psram_pd_keyreg
    import pd_key_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int NSEG   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pgm_stb,
    input  logic              acc_stb,
    input  logic              pd_req,
    output logic [1:0]        mode_o,
    output logic [NSEG-1:0]   mask_o,
    output logic              err_o
);
    key_dec_t  dec;
    pd_key_t   key_q;
    pwr_mode_e mode_q;

    pd_key_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    pd_key_store u_store (
        .clk     (clk),
        .rst     (rst),
        .live    (!pd_req),
        .pgm_stb (pgm_stb),
        .acc_stb (acc_stb),
        .dec     (dec),
        .key_q   (key_q),
        .err_q   (err_o)
    );

    pd_power_ctrl #(.NSEG(NSEG)) u_pwr (
        .clk    (clk),
        .rst    (rst),
        .pd_req (pd_req),
        .key    (key_q),
        .mode_q (mode_q),
        .mask_q (mask_o)
    );

    assign mode_o = mode_q;
endmodule

// File: rtl/pd_keyreg_checker.sv
module pd_keyreg_checker #(
    parameter int NSEG = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            pd_req,
    input logic [1:0]      mode_o,
    input logic [NSEG-1:0] mask_o,
    input logic            err_o
);
    assert_err_sticky_R13: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    assert_exit_active_R10: assert property (@(posedge clk) disable iff (rst)
        !pd_req |=> (mode_o == 2'd0));

    assert_enter_lowpower_R10: assert property (@(posedge clk) disable iff (rst)
        pd_req |=> (mode_o != 2'd0));

    assert_mode_held_R10: assert property (@(posedge clk) disable iff (rst)
        (pd_req && mode_o != 2'd0) |=> $stable(mode_o));

    assert_mask_shrinks_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((mask_o & ~$past(mask_o)) == '0));

    assert_nodata_modes_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd1 || mode_o == 2'd3) |-> (mask_o == '0));

    assert_partial_one_region_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |-> ($countones(mask_o) <= 1));
endmodule

bind psram_pd_keyreg pd_keyreg_checker #(.NSEG(NSEG)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .pd_req (pd_req),
    .mode_o (mode_o),
    .mask_o (mask_o),
    .err_o  (err_o)
);

// File: tb/psram_pd_keyreg_tb.sv
module psram_pd_keyreg_tb;
    localparam int AW = 22;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          pgm_stb = 1'b0;
    logic          acc_stb = 1'b0;
    logic          pd_req = 1'b0;
    logic [1:0]    mode_o;
    logic [NS-1:0] mask_o;
    logic          err_o;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state
    logic [1:0]    m_mode;
    logic [NS-1:0] m_mask;
    logic          m_err;
    logic [1:0]    m_kmode;
    logic          m_ktop;
    logic          m_lock;
    logic          m_touch;

    always #4 clk = ~clk;

    psram_pd_keyreg #(.ADDR_W(AW), .NSEG(NS)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .pgm_stb(pgm_stb),
        .acc_stb(acc_stb), .pd_req(pd_req),
        .mode_o(mode_o), .mask_o(mask_o), .err_o(err_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_mask = '1; m_err = 0;
            m_kmode = 3; m_ktop = 0; m_lock = 0; m_touch = 0;
        end else if (pd_req) begin
            if (m_mode == 0) begin
                m_mode = m_kmode;
                if (m_kmode == 2) m_mask = m_mask & (m_ktop ? 4'b1000 : 4'b0001);
                else m_mask = '0;
            end
        end else begin
            m_mode = 0;
            if (pgm_stb) begin
                int  km;
                bit  bad;
                logic [2:0] ac;
                ac  = {addr[18], addr[21], addr[20]};
                bad = 0;
                if (!addr[0] && !addr[8]) km = 1;
                else if (addr[0] && !addr[8]) km = 2;
                else if (addr[0] && addr[8]) km = 3;
                else begin km = 0; bad = 1; end
                if (km == 2 && ac != 3'b000 && ac != 3'b111) bad = 1;
                if (bad || m_lock || m_touch) m_err = 1;
                else begin
                    m_kmode = km[1:0];
                    m_ktop  = (ac == 3'b111);
                    m_lock  = 1;
                end
            end
            if (acc_stb) m_touch = 1;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("mode_o", int'(mode_o), int'(m_mode));
            chk("mask_o", int'(mask_o), int'(m_mask));
            chk("err_o", int'(err_o), int'(m_err));
        end
    end

    task automatic tick(input logic p, input logic a, input logic d, input logic [AW-1:0] ad);
        pgm_stb = p; acc_stb = a; pd_req = d; addr = ad;
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] mk(input logic a0, input logic a8,
                                         input logic a18, input logic a21, input logic a20);
        logic [AW-1:0] r;
        r = AW'($urandom);
        r[0] = a0; r[8] = a8; r[18] = a18; r[21] = a21; r[20] = a20;
        return r;
    endfunction

    task automatic do_reset();
        rst = 1; tick(0, 0, 0, '0); tick(0, 0, 0, '0);
        rst = 0; tick(0, 0, 0, '0);
    endtask

    task automatic pd_cycle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 1, AW'($urandom));
        tick(0, 0, 0, '0); tick(0, 0, 0, '0);
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R1"; do_reset();
        cur_req = "R5"; pd_cycle(3);
        cur_req = "R11"; pd_cycle(2);

        cur_req = "R9"; do_reset();
        tick(1, 0, 0, mk(1, 0, 0, 0, 0)); tick(0, 0, 0, '0);
        cur_req = "R3"; pd_cycle(3);
        cur_req = "R11"; pd_cycle(2);

        cur_req = "R3"; do_reset();
        tick(1, 0, 0, mk(1, 0, 1, 1, 1)); tick(0, 0, 0, '0);
        pd_cycle(4);

        cur_req = "R4"; do_reset();
        tick(1, 0, 0, mk(0, 0, 0, 1, 0)); tick(0, 0, 0, '0);
        pd_cycle(2);
        do_reset();
        tick(1, 0, 0, mk(1, 1, 1, 0, 1)); tick(0, 0, 0, '0);
        pd_cycle(2);

        cur_req = "R8"; do_reset();
        tick(1, 0, 0, mk(0, 1, 0, 0, 0)); tick(0, 0, 0, '0);
        pd_cycle(2);
        do_reset();
        tick(1, 0, 0, mk(1, 0, 0, 1, 0)); tick(0, 0, 0, '0);
        tick(1, 0, 0, mk(1, 0, 1, 1, 1)); tick(0, 0, 0, '0);
        pd_cycle(2);

        cur_req = "R6"; do_reset();
        tick(1, 0, 0, mk(0, 0, 0, 0, 0)); tick(0, 0, 0, '0);
        tick(1, 0, 0, mk(1, 0, 0, 0, 0)); tick(0, 0, 0, '0);
        pd_cycle(2);
        cur_req = "R13"; for (int i = 0; i < 5; i++) tick(0, 1, 0, '0);

        cur_req = "R7"; do_reset();
        tick(0, 1, 0, '0);
        tick(1, 0, 0, mk(1, 0, 0, 0, 0)); tick(0, 0, 0, '0);
        pd_cycle(2);
        do_reset();
        tick(1, 1, 0, mk(1, 0, 1, 1, 1)); tick(0, 0, 0, '0);
        pd_cycle(2);

        cur_req = "R12"; do_reset();
        tick(0, 0, 1, '0);
        tick(1, 1, 1, mk(0, 1, 0, 0, 0));
        tick(1, 0, 1, mk(0, 0, 0, 0, 0));
        tick(0, 0, 0, '0); tick(0, 0, 0, '0);
        tick(1, 0, 0, mk(1, 0, 0, 0, 0)); tick(0, 0, 0, '0);
        pd_cycle(3);

        cur_req = "R10"; do_reset();
        tick(1, 0, 0, mk(1, 0, 1, 1, 1)); tick(0, 0, 0, '0);
        for (int i = 0; i < 6; i++) tick(0, 0, i[0], '0);
        cur_req = "R2"; do_reset();
        for (int i = 0; i < 20; i++) begin
            tick($urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 2) == 0, AW'($urandom));
        end

        tick(0, 0, 0, '0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule